// File: doc/BRIEF.md
# Floating-Point to Integer Converter with Wrapping Result

This block turns a binary64 floating-point operand into a 64-bit two's-complement integer in one registered stage. The rounding mode is chosen per operation. Results that are too large are not clamped. The block returns the low 64 bits of the exact integer, so callers that want an unsigned conversion can take the same result and read it as unsigned.

A separate report enable decides whether the overflow and inexact flags may be raised. A caller that wants a chopped, silent conversion drives the toward-zero mode with reporting off. A caller that wants a chopped conversion with full flags drives the toward-zero mode with reporting on. NaN operands raise the invalid flag in every case.

Rounding works on the magnitude. The bits shifted out to the right are collected into a left-aligned residue word as wide as the result, so an exact half is a single compare. The sign is applied after rounding, by negation.

Top module: `dti_conv`

## Requirements
- R1: `valid_o` is high in the cycle after a cycle with `valid_i` high, and low after a cycle with `valid_i` low. `result_o` and the flags belong to the operand accepted in that previous cycle. Reset clears `valid_o`, `result_o` and all flags.
- R2: Zero operands of either sign give result 0 with no flags. An operand with biased exponent 0 and a nonzero fraction has a magnitude of 0 and a residue of exactly 1 (a lone sticky bit), and is then rounded and signed as in R7 to R12.
- R3: A biased exponent of all ones gives result 0. A nonzero fraction raises `invalid_o` whatever `report_i` is. A zero fraction raises `overflow_o` only when `report_i` is 1. `invalid_o` is never raised for any other operand.
- R4: For a normal operand, the significand is the fraction with a 1 restored above bit 51, and the shift is the biased exponent minus 1075. For a shift from 0 to 62, the magnitude is the significand shifted left, truncated to 64 bits. `overflow_o` rises, when reporting is enabled, exactly when significand bits are lost above bit 63.
- R5: A shift of 63 or more gives result 0 and raises no flag.
- R6: For a negative shift of magnitude k below 63, the magnitude is the significand shifted right by k. The k discarded bits, left-aligned, form the 64-bit residue. For k of 63 or more, the magnitude is 0 and the residue is 1.
- R7: A nonzero residue raises `inexact_o` when `report_i` is 1. A zero residue raises no flag. `inexact_o` never rises together with `overflow_o` or `invalid_o`.
- R8: Mode 2'b00 rounds to nearest even. It adds 1 to the magnitude when the residue exceeds 2^63. When the residue equals 2^63, it adds the magnitude's bit 0.
- R9: Mode 2'b01 rounds toward zero and adds nothing to the magnitude.
- R10: Mode 2'b10 rounds toward minus infinity. It adds 1 to the magnitude only for a negative operand with a nonzero residue.
- R11: Mode 2'b11 rounds toward plus infinity. It adds 1 to the magnitude only for a positive operand with a nonzero residue.
- R12: When the sign bit (bit 63) is set, the result is the two's-complement negation of the rounded magnitude, modulo 2^64.
- R13: With `report_i` at 0, `overflow_o` and `inexact_o` stay low. `report_i` never changes `result_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand present this cycle |
| operand_i | input | 64 | binary64 operand: sign bit 63, exponent bits 62:52, fraction bits 51:0 |
| rmode_i | input | 2 | Rounding mode: 00 nearest even, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity |
| report_i | input | 1 | Allows overflow and inexact flags |
| valid_o | output | 1 | Result present this cycle |
| result_o | output | 64 | Wrapped two's-complement integer |
| invalid_o | output | 1 | NaN operand |
| overflow_o | output | 1 | Infinite operand or lost high bits, when reporting |
| inexact_o | output | 1 | Nonzero residue, when reporting |

## Verification
The bench builds the block with its default widths: an 11-bit exponent, a 52-bit fraction and a 64-bit integer. These are the only widths at which the 1075 shift origin, the 63-position limits and the 2^63 half point exist, so they are the values used.

At these widths, directed operands can sit on each boundary:
- shifts of exactly 0, 11, 12, 62 and 63;
- ties at one half against even and odd magnitudes;
- subnormal sticky operands in every mode;
- infinities and NaNs with and without reporting.

Random operands, with exponents grouped around the shift origin and the unit point, are compared against a model of the same wrapping algorithm in all four modes.

// File: rtl/dti_pkg.sv
package dti_pkg;
  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_DOWN    = 2'b10,
    RM_UP      = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    CL_ZERO    = 2'b00,
    CL_SUBNORM = 2'b01,
    CL_NORMAL  = 2'b10,
    CL_SPECIAL = 2'b11
  } cls_e;
endpackage

// File: rtl/dti_unpack.sv
module dti_unpack
  import dti_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
  input  logic [OP_W-1:0]   op_i,
  output logic              sign_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [FRAC_W:0]   sig_o,
  output cls_e              cls_o,
  output logic              frac_nz_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              nz;
  cls_e              cls;

  always_comb begin
    exp_f  = op_i[OP_W-2:FRAC_W];
    frac_f = op_i[FRAC_W-1:0];
    nz     = |frac_f;
    if (exp_f == '0)      cls = nz ? CL_SUBNORM : CL_ZERO;
    else if (&exp_f)      cls = CL_SPECIAL;
    else                  cls = CL_NORMAL;
  end

  assign sign_o    = op_i[OP_W-1];
  assign exp_o     = exp_f;
  assign frac_nz_o = nz;
  assign cls_o     = cls;
  // hidden bit only for normal operands
  assign sig_o     = {cls == CL_NORMAL, frac_f};
endmodule

// File: rtl/dti_align.sv
module dti_align
  import dti_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 64
) (
  input  cls_e              cls_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [FRAC_W:0]   sig_i,
  output logic [INT_W-1:0]  mag_o,
  output logic [INT_W-1:0]  resid_o,
  output logic              lost_o
);
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int WIDE_W = INT_W + FRAC_W + 1;
  localparam int PAD_W  = INT_W - FRAC_W - 1;
  localparam logic [EXP_W-1:0] ORIGIN = EXP_W'(BIAS + FRAC_W);
  localparam logic [EXP_W-1:0] LIMIT  = EXP_W'(INT_W - 1);
  localparam logic [INT_W-1:0] STICKY = INT_W'(1);

  logic [EXP_W-1:0]   lsh, rsh;
  logic [WIDE_W-1:0]  lwide;
  logic [2*INT_W-1:0] rwide;
  logic [INT_W-1:0]   sig_ext;

  assign sig_ext = {{PAD_W{1'b0}}, sig_i};
  assign lsh     = exp_i - ORIGIN;
  assign rsh     = ORIGIN - exp_i;
  assign lwide   = {{INT_W{1'b0}}, sig_i} << lsh;
  // integer part in upper half, discarded bits left-aligned in lower half
  assign rwide   = {sig_ext, {INT_W{1'b0}}} >> rsh;

  always_comb begin
    mag_o   = '0;
    resid_o = '0;
    lost_o  = 1'b0;
    case (cls_i)
      CL_SUBNORM: resid_o = STICKY;
      CL_NORMAL: begin
        if (exp_i >= ORIGIN) begin
          if (lsh < LIMIT) begin
            mag_o  = lwide[INT_W-1:0];
            lost_o = |lwide[WIDE_W-1:INT_W];
          end
        end else if (rsh < LIMIT) begin
          mag_o   = rwide[2*INT_W-1:INT_W];
          resid_o = rwide[INT_W-1:0];
        end else begin
          resid_o = STICKY;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dti_round.sv
module dti_round
  import dti_pkg::*;
#(
  parameter int INT_W = 64
) (
  input  logic              sign_i,
  input  logic [INT_W-1:0]  mag_i,
  input  logic [INT_W-1:0]  resid_i,
  input  rmode_e            rmode_i,
  output logic [INT_W-1:0]  res_o
);
  localparam logic [INT_W-1:0] HALF = {1'b1, {(INT_W-1){1'b0}}};

  logic             inc;
  logic [INT_W-1:0] sum;

  always_comb begin
    inc = 1'b0;
    if (resid_i != '0) begin
      case (rmode_i)
        RM_NEAREST: inc = (resid_i > HALF) || ((resid_i == HALF) && mag_i[0]);
        RM_ZERO:    inc = 1'b0;
        RM_DOWN:    inc = sign_i;
        RM_UP:      inc = !sign_i;
        default:    inc = 1'b0;
      endcase
    end
    sum   = mag_i + {{(INT_W-1){1'b0}}, inc};
    res_o = sign_i ? ({INT_W{1'b0}} - sum) : sum;
  end
endmodule

// File: rtl/dti_conv.sv
module dti_conv
  import dti_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 64,
  localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   operand_i,
  input  logic [1:0]        rmode_i,
  input  logic              report_i,
  output logic              valid_o,
  output logic [INT_W-1:0]  result_o,
  output logic              invalid_o,
  output logic              overflow_o,
  output logic              inexact_o
);
  logic             sign;
  logic [EXP_W-1:0] exp_f;
  logic [FRAC_W:0]  sig;
  cls_e             cls;
  logic             frac_nz;
  logic [INT_W-1:0] mag, resid, res;
  logic             lost;
  logic             inv_d, ovf_d, inx_d;
  rmode_e           rm;

  assign rm = rmode_e'(rmode_i);

  dti_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_unpack (
    .op_i      (operand_i),
    .sign_o    (sign),
    .exp_o     (exp_f),
    .sig_o     (sig),
    .cls_o     (cls),
    .frac_nz_o (frac_nz)
  );

  dti_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) i_align (
    .cls_i   (cls),
    .exp_i   (exp_f),
    .sig_i   (sig),
    .mag_o   (mag),
    .resid_o (resid),
    .lost_o  (lost)
  );

  dti_round #(.INT_W(INT_W)) i_round (
    .sign_i  (sign),
    .mag_i   (mag),
    .resid_i (resid),
    .rmode_i (rm),
    .res_o   (res)
  );

  assign inv_d = (cls == CL_SPECIAL) && frac_nz;
  assign ovf_d = report_i && (lost || ((cls == CL_SPECIAL) && !frac_nz));
  assign inx_d = report_i && (resid != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      result_o   <= '0;
      invalid_o  <= 1'b0;
      overflow_o <= 1'b0;
      inexact_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o   <= res;
        invalid_o  <= inv_d;
        overflow_o <= ovf_d;
        inexact_o  <= inx_d;
      end
    end
  end
endmodule

// File: rtl/dti_conv_chk.sv
module dti_conv_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 64,
  localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [OP_W-1:0]   operand_i,
  input logic [1:0]        rmode_i,
  input logic              report_i,
  input logic              valid_o,
  input logic [INT_W-1:0]  result_o,
  input logic              invalid_o,
  input logic              overflow_o,
  input logic              inexact_o
);
  logic [EXP_W-1:0] exp_f;
  logic             frac_nz;
  assign exp_f   = operand_i[OP_W-2:FRAC_W];
  assign frac_nz = |operand_i[FRAC_W-1:0];

  // R1
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R3
  special_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (&exp_f)) |=> (result_o == '0));
  // R3
  nan_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (&exp_f) && frac_nz) |=> invalid_o);
  // R3
  finite_no_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !(&exp_f)) |=> !invalid_o);
  // R13
  silent_report_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !report_i) |=> (!overflow_o && !inexact_o));
  // R2
  subnorm_chop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (exp_f == '0) && (rmode_i == 2'b01)) |=> (result_o == '0));
  // R7
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({invalid_o, overflow_o, inexact_o}));
endmodule

bind dti_conv dti_conv_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) i_dti_conv_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .operand_i  (operand_i),
  .rmode_i    (rmode_i),
  .report_i   (report_i),
  .valid_o    (valid_o),
  .result_o   (result_o),
  .invalid_o  (invalid_o),
  .overflow_o (overflow_o),
  .inexact_o  (inexact_o)
);

// File: tb/test_dti_conv.sv
module test_dti_conv;
  timeunit 1ns;
  timeprecision 1ps;

  typedef struct {
    logic [63:0] op;
    logic [1:0]  rm;
    logic        rep;
    logic [63:0] r;
    logic        inv;
    logic        ovf;
    logic        inx;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] operand_i = '0;
  logic [1:0]  rmode_i = '0;
  logic        report_i = 1'b0;
  logic        valid_o;
  logic [63:0] result_o;
  logic        invalid_o, overflow_o, inexact_o;

  int checks = 0;
  int fails  = 0;
  item_t q[$];

  always #2.5 clk = ~clk;

  dti_conv i_dti_conv (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .valid_i    (valid_i),
    .operand_i  (operand_i),
    .rmode_i    (rmode_i),
    .report_i   (report_i),
    .valid_o    (valid_o),
    .result_o   (result_o),
    .invalid_o  (invalid_o),
    .overflow_o (overflow_o),
    .inexact_o  (inexact_o)
  );

  // model of the requirements, R2 to R13
  function automatic void model(input logic [63:0] a, input logic [1:0] rm, input logic rep,
                                output logic [63:0] r, output logic inv, output logic ovf,
                                output logic inx);
    int e, sh;
    logic [63:0] sig, mag, resid;
    logic [127:0] w;
    logic up;
    e = int'(a[62:52]);
    sig = {11'd0, 1'b1, a[51:0]};
    mag = '0; resid = '0; inv = 1'b0; ovf = 1'b0; inx = 1'b0; up = 1'b0;
    r = '0;
    if (e == 2047) begin
      inv = |a[51:0];
      ovf = rep && !inv;
      return;
    end
    if (e == 0) begin
      if (a[51:0] == '0) return;
      resid = 64'd1;
    end else begin
      sh = e - 1075;
      if (sh >= 0) begin
        if (sh < 63) begin
          w = {64'd0, sig} << sh;
          mag = w[63:0];
          ovf = rep && (w[127:64] != '0);
        end
      end else begin
        sh = -sh;
        if (sh < 63) begin
          mag = sig >> sh;
          resid = sig << (64 - sh);
        end else resid = 64'd1;
      end
    end
    if (resid != '0) begin
      inx = rep;
      case (rm)
        2'b00: up = (resid > 64'h8000_0000_0000_0000) ||
                    (resid == 64'h8000_0000_0000_0000 && mag[0]);
        2'b01: up = 1'b0;
        2'b10: up = a[63];
        default: up = !a[63];
      endcase
    end
    mag = mag + {63'd0, up};
    r = a[63] ? (64'd0 - mag) : mag;
  endfunction

  task automatic drive(input logic [63:0] op, input logic [1:0] rm, input logic rep,
                       input logic [63:0] r, input logic inv, input logic ovf,
                       input logic inx, input string req);
    item_t it;
    @(negedge clk);
    valid_i = 1'b1; operand_i = op; rmode_i = rm; report_i = rep;
    it.op = op; it.rm = rm; it.rep = rep; it.r = r;
    it.inv = inv; it.ovf = ovf; it.inx = inx; it.req = req;
    q.push_back(it);
  endtask

  task automatic drive_model(input logic [63:0] op, input logic [1:0] rm, input logic rep,
                             input string req);
    logic [63:0] r;
    logic a, b, c;
    model(op, rm, rep, r, a, b, c);
    drive(op, rm, rep, r, a, b, c, req);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R1 unexpected valid_o actual=1 expected=0");
      end else begin
        item_t it;
        it = q.pop_front();
        if (result_o !== it.r || invalid_o !== it.inv || overflow_o !== it.ovf ||
            inexact_o !== it.inx) begin
          fails++;
          $display("FAIL %s op=%h rm=%0d rep=%0b actual=%h i%b o%b x%b expected=%h i%b o%b x%b",
                   it.req, it.op, it.rm, it.rep, result_o, invalid_o, overflow_o, inexact_o,
                   it.r, it.inv, it.ovf, it.inx);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || result_o !== '0 || invalid_o || overflow_o || inexact_o) begin
      fails++;
      $display("FAIL R1 reset state actual=%b/%h expected=0/0", valid_o, result_o);
    end

    // R2 zeros and subnormals
    drive(64'h0000_0000_0000_0000, 2'b00, 1'b1, 64'd0, 0, 0, 0, "R2 +zero");
    drive(64'h8000_0000_0000_0000, 2'b10, 1'b1, 64'd0, 0, 0, 0, "R2 -zero");
    drive(64'h0000_0000_0000_0001, 2'b11, 1'b1, 64'd1, 0, 0, 1, "R2 subnorm up");
    drive(64'h0000_0000_0000_0001, 2'b00, 1'b1, 64'd0, 0, 0, 1, "R2 subnorm nearest");
    drive(64'h8000_0000_0000_0001, 2'b10, 1'b1, ONES, 0, 0, 1, "R2 neg subnorm down");
    drive(64'h8000_0000_0000_0001, 2'b11, 1'b0, 64'd0, 0, 0, 0, "R2 neg subnorm up");
    // R3 specials
    drive(64'h7FF0_0000_0000_0000, 2'b00, 1'b1, 64'd0, 0, 1, 0, "R3 inf report");
    drive(64'hFFF0_0000_0000_0000, 2'b00, 1'b0, 64'd0, 0, 0, 0, "R3 inf silent");
    drive(64'h7FF8_0000_0000_0000, 2'b01, 1'b0, 64'd0, 1, 0, 0, "R3 nan silent");
    drive(64'hFFF0_0000_0000_0001, 2'b00, 1'b1, 64'd0, 1, 0, 0, "R3 nan report");
    // R4 left shifts
    drive(64'h4330_0000_0000_0000, 2'b00, 1'b1, 64'h0010_0000_0000_0000, 0, 0, 0, "R4 shift zero");
    drive(64'h43E0_0000_0000_0000, 2'b00, 1'b1, 64'h8000_0000_0000_0000, 0, 0, 0, "R4 two pow 63");
    drive(64'h43E8_0000_0000_0000, 2'b00, 1'b1, 64'hC000_0000_0000_0000, 0, 0, 0, "R4 wrap no loss");
    drive(64'h43F0_0000_0000_0000, 2'b00, 1'b1, 64'd0, 0, 1, 0, "R4 two pow 64");
    drive(64'hC3E0_0000_0000_0000, 2'b01, 1'b1, 64'h8000_0000_0000_0000, 0, 0, 0, "R4 R12 neg pow 63");
    drive(64'h4710_0000_0000_0000, 2'b00, 1'b1, 64'd0, 0, 1, 0, "R4 shift 62");
    // R5
    drive(64'h4720_0000_0000_0000, 2'b00, 1'b1, 64'd0, 0, 0, 0, "R5 shift 63");
    // R6 R7
    drive(64'h3ED0_0000_0000_0000, 2'b11, 1'b1, 64'd1, 0, 0, 1, "R6 deep sticky up");
    drive(64'h3ED0_0000_0000_0000, 2'b00, 1'b1, 64'd0, 0, 0, 1, "R6 deep sticky nearest");
    drive(64'h3FF0_0000_0000_0000, 2'b00, 1'b1, 64'd1, 0, 0, 0, "R7 exact one");
    // R8
    drive(64'h3FF8_0000_0000_0000, 2'b00, 1'b1, 64'd2, 0, 0, 1, "R8 1.5 tie odd");
    drive(64'h4004_0000_0000_0000, 2'b00, 1'b1, 64'd2, 0, 0, 1, "R8 2.5 tie even");
    drive(64'h3FE0_0000_0000_0000, 2'b00, 1'b1, 64'd0, 0, 0, 1, "R8 0.5 tie zero");
    drive(64'h3FE8_0000_0000_0000, 2'b00, 1'b1, 64'd1, 0, 0, 1, "R8 0.75 above half");
    drive(64'hC004_0000_0000_0000, 2'b00, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 0, 0, 1, "R8 R12 -2.5");
    // R9
    drive(64'h3FF8_0000_0000_0000, 2'b01, 1'b1, 64'd1, 0, 0, 1, "R9 1.5 chop");
    drive(64'hBFFC_0000_0000_0000, 2'b01, 1'b1, ONES, 0, 0, 1, "R9 R12 -1.75 chop");
    // R10
    drive(64'hBFF8_0000_0000_0000, 2'b10, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 0, 0, 1, "R10 -1.5 down");
    drive(64'h3FF8_0000_0000_0000, 2'b10, 1'b1, 64'd1, 0, 0, 1, "R10 1.5 down");
    // R11
    drive(64'h3FF8_0000_0000_0000, 2'b11, 1'b1, 64'd2, 0, 0, 1, "R11 1.5 up");
    drive(64'hBFF8_0000_0000_0000, 2'b11, 1'b1, ONES, 0, 0, 1, "R11 -1.5 up");
    idle(2);
    // R13
    drive(64'h3FF8_0000_0000_0000, 2'b00, 1'b0, 64'd2, 0, 0, 0, "R13 1.5 silent");
    drive(64'h43F0_0000_0000_0000, 2'b00, 1'b0, 64'd0, 0, 0, 0, "R13 pow 64 silent");
    idle(1);

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] op;
      int e;
      op = {$urandom, $urandom};
      case ($urandom % 4)
        0: e = 1010 + int'($urandom % 130);
        1: e = 1013 + int'($urandom % 80);
        2: e = int'($urandom % 2048);
        default: e = ($urandom % 2 == 0) ? 0 : 2047;
      endcase
      op[62:52] = 11'(e);
      if ($urandom % 8 == 0) op[51:0] = {op[51:48], 48'd0};
      drive_model(op, 2'($urandom), 1'($urandom), "R12 random");
      if ($urandom % 10 == 0) idle(1);
    end

    idle(3);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R1 results missing actual=%0d pending expected=0", q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule